// File: doc/BRIEF.md
# Standby Clock Enable Controller

This block sits beside the fetch stage of a small 8-bit controller core and manages its two standby levels. It watches the opcodes the core accepts. It drives three enables: one for the CPU system clock, one for the clock that feeds the timers and interrupt logic, and one for the oscillator. It also tells the fetch unit when to resume and when to restart.

The first standby level is the light one. It is entered with opcode 7Fh and gates only the CPU clock, so timers and interrupts keep running. Any pending interrupt that is enabled ends it, and execution then continues at the next instruction. The deep level is entered with opcode 6Fh and shuts down all clocks, including the oscillator. It ends only on reset or on a high level at a dedicated wake pin. After a settling delay, the fetch unit is told to restart at a fixed vector.

A pipeline-flush NOP (FFh) must come directly before either standby opcode. The block reports whether the last accepted opcode was that NOP. It also keeps a sticky flag for any standby entry made without one. The entry itself still happens.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after its release, all three enables are 1, `mode` is 0 (run), `unflushed_entry` and `flush_ready` are 0, and `restart_req` is 1. `restart_req` drops to 0 at the first clock edge after release.
- R2: In run mode, an accepted opcode 7Fh (op_valid high) makes `mode` 1 (halt) and `sclk_en` 0 from the next cycle. `tclk_en` and `osc_en` stay 1.
- R3: In run mode, an accepted opcode 6Fh makes `mode` 2 (stop) and drives all three enables to 0 from the next cycle.
- R4: In halt, a request with `irq_req[i]` and `irq_en[i]` both 1 returns `mode` to 0 and `sclk_en` to 1 in the next cycle. In that same cycle `resume_pulse` is 1, and it is 1 for exactly one cycle. A request whose enable bit is 0 does not wake the block.
- R5: Inputs outside a level's wake source have no effect. Interrupts are ignored in stop, the wake pin is ignored in run and halt, and opcodes are ignored in every mode except run.
- R6: In stop, a high `wake_pin` passes two synchronizer stages. At the third clock edge after it goes high, `mode` becomes 3 (settle) and `osc_en` becomes 1, while `sclk_en` and `tclk_en` stay 0.
- R7: The settle mode lasts max(`settle_cycles`,1) cycles, using the value sampled on entry. After that, `mode` returns to 0, all enables are 1, and `restart_req` is 1 for exactly one cycle. `restart_vec` always reads 00Ch.
- R8: `flush_ready` is 1 exactly when the last opcode accepted in run mode was FFh. It is cleared by reset and by a restart from stop.
- R9: An accepted 7Fh or 6Fh while `flush_ready` is 0 still enters the level and sets `unflushed_entry`. This flag stays 1 until reset.
- R10: Reset overrides every other input in every mode and returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode on op_code is accepted this cycle |
| op_code | input | 8 | Opcode from the instruction stream |
| irq_req | input | IRQ_W | Pending interrupt requests |
| irq_en | input | IRQ_W | Per-request enable mask, 1 = enabled |
| wake_pin | input | 1 | Asynchronous wake pin for stop mode |
| settle_cycles | input | CNT_W | Oscillator settling length in cycles |
| sclk_en | output | 1 | CPU system clock enable |
| tclk_en | output | 1 | Timer/interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 0 run, 1 halt, 2 stop, 3 settle |
| resume_pulse | output | 1 | One-cycle resume-after-halt indication |
| restart_req | output | 1 | Restart request to the fetch unit |
| restart_vec | output | VEC_W | Restart address, 00Ch |
| flush_ready | output | 1 | Last accepted opcode was the flush NOP |
| unflushed_entry | output | 1 | Sticky: standby entered without flush NOP |

## Verification
Opcode decoding and wake from halt take effect one edge after the input is driven. Pin wake from stop takes effect three edges after the pin goes high, because of the synchronizer. The return to run comes `settle_cycles` edges after settle mode is entered. The bench drives inputs on the falling edge and compares on the following falling edge against a cycle model built from these latencies. Directed sequences count the edges out explicitly around each transition, for example checking that stop still holds after two edges of a high pin. A long random run with sparse resets then compares every output on every cycle.

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl #(
  parameter int IRQ_W = 6,
  parameter int CNT_W = 8,
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] RESTART_VEC = 'h00C,
  parameter logic [7:0] OP_NOP  = 8'hFF,
  parameter logic [7:0] OP_HALT = 8'h7F,
  parameter logic [7:0] OP_STOP = 8'h6F
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  input  logic [IRQ_W-1:0] irq_req,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             wake_pin,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             sclk_en,
  output logic             tclk_en,
  output logic             osc_en,
  output logic [1:0]       mode,
  output logic             resume_pulse,
  output logic             restart_req,
  output logic [VEC_W-1:0] restart_vec,
  output logic             flush_ready,
  output logic             unflushed_entry
);

  localparam logic [1:0] M_RUN = 2'd0, M_HALT = 2'd1, M_STOP = 2'd2, M_SETTLE = 2'd3;

  logic [1:0]       pin_sync;
  logic [CNT_W-1:0] settle_cnt;

  wire run_op      = op_valid && (mode == M_RUN);
  wire halt_op     = run_op && (op_code == OP_HALT);
  wire stop_op     = run_op && (op_code == OP_STOP);
  wire irq_wake    = (mode == M_HALT) && |(irq_req & irq_en);
  wire pin_wake    = (mode == M_STOP) && pin_sync[1];
  wire settle_done = (mode == M_SETTLE) && (settle_cnt <= 1);

  assign restart_vec = RESTART_VEC;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[0], wake_pin};
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mode            <= M_RUN;
      sclk_en         <= 1'b1;
      tclk_en         <= 1'b1;
      osc_en          <= 1'b1;
      resume_pulse    <= 1'b0;
      restart_req     <= 1'b1;
      flush_ready     <= 1'b0;
      unflushed_entry <= 1'b0;
      settle_cnt      <= '0;
    end else begin
      resume_pulse <= irq_wake;
      restart_req  <= settle_done;
      case (mode)
        M_RUN: begin
          if (run_op) flush_ready <= (op_code == OP_NOP);
          if ((halt_op || stop_op) && !flush_ready) unflushed_entry <= 1'b1;
          if (halt_op) begin
            mode    <= M_HALT;
            sclk_en <= 1'b0;
          end else if (stop_op) begin
            mode    <= M_STOP;
            sclk_en <= 1'b0;
            tclk_en <= 1'b0;
            osc_en  <= 1'b0;
          end
        end
        M_HALT: if (irq_wake) begin
          mode    <= M_RUN;
          sclk_en <= 1'b1;
        end
        M_STOP: if (pin_wake) begin
          mode       <= M_SETTLE;
          osc_en     <= 1'b1;
          settle_cnt <= settle_cycles;
        end
        default: begin
          if (settle_done) begin
            mode        <= M_RUN;
            sclk_en     <= 1'b1;
            tclk_en     <= 1'b1;
            flush_ready <= 1'b0;
          end else begin
            settle_cnt <= settle_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assert_halt_gating_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == M_HALT) |-> (!sclk_en && tclk_en && osc_en));

  assert_stop_gating_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == M_STOP) |-> (!sclk_en && !tclk_en && !osc_en));

  assert_resume_single_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  assert_resume_from_halt_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == M_HALT && |(irq_req & irq_en)) |=> (mode == M_RUN && sclk_en && resume_pulse));

  assert_settle_clocks_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == M_SETTLE) |-> (osc_en && !tclk_en && !sclk_en));

  assert_restart_single_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (restart_req && mode == M_RUN && $past(mode) == M_SETTLE) |=> !restart_req);

  assert_sticky_unflushed_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    unflushed_entry |=> unflushed_entry);

  assert_stop_ignores_irq_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == M_STOP && !pin_sync[1]) |=> (mode == M_STOP));

endmodule

// File: tb/lpm_clock_ctrl_bench.sv
module lpm_clock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W = 6;
  localparam int CNT_W = 8;
  localparam int VEC_W = 12;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, wake_pin = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [IRQ_W-1:0] irq_req = '0, irq_en = '0;
  logic [CNT_W-1:0] settle_cycles = 8'd4;
  logic sclk_en, tclk_en, osc_en, resume_pulse, restart_req, flush_ready, unflushed_entry;
  logic [1:0] mode;
  logic [VEC_W-1:0] restart_vec;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_clock_ctrl #(.IRQ_W(IRQ_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_lpm_clock_ctrl (
    .clk_ref(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .irq_req(irq_req), .irq_en(irq_en), .wake_pin(wake_pin), .settle_cycles(settle_cycles),
    .sclk_en(sclk_en), .tclk_en(tclk_en), .osc_en(osc_en), .mode(mode),
    .resume_pulse(resume_pulse), .restart_req(restart_req), .restart_vec(restart_vec),
    .flush_ready(flush_ready), .unflushed_entry(unflushed_entry));

  // Cycle model built from the requirement latencies
  logic [1:0] m_mode, m_pin;
  logic m_sclk, m_tclk, m_osc, m_res, m_rst, m_flush, m_unfl;
  int m_cnt;

  function automatic logic [8:0] pack(logic s, logic t, logic o, logic [1:0] md,
                                      logic rs, logic rr, logic fl, logic uf);
    return {s, t, o, md, rs, rr, fl, uf};
  endfunction

  function automatic int settle_len(logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sclk = 1; m_tclk = 1; m_osc = 1; m_res = 0; m_rst = 1;
      m_flush = 0; m_unfl = 0; m_pin = 0; m_cnt = 0;
    end else begin
      m_res = 0; m_rst = 0;
      case (m_mode)
        2'd0: if (op_valid) begin
          if ((op_code == 8'h7F || op_code == 8'h6F) && !m_flush) m_unfl = 1;
          m_flush = (op_code == 8'hFF);
          if (op_code == 8'h7F) begin m_mode = 1; m_sclk = 0; end
          else if (op_code == 8'h6F) begin m_mode = 2; m_sclk = 0; m_tclk = 0; m_osc = 0; end
        end
        2'd1: if ((irq_req & irq_en) != 0) begin m_mode = 0; m_sclk = 1; m_res = 1; end
        2'd2: if (m_pin[1]) begin m_mode = 3; m_osc = 1; m_cnt = settle_len(settle_cycles); end
        default: begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_mode = 0; m_sclk = 1; m_tclk = 1; m_rst = 1; m_flush = 0; end
        end
      endcase
      m_pin = {m_pin[0], wake_pin};
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_model(string req);
    check(req, 32'(pack(sclk_en, tclk_en, osc_en, mode, resume_pulse, restart_req, flush_ready, unflushed_entry)),
          32'(pack(m_sclk, m_tclk, m_osc, m_mode, m_res, m_rst, m_flush, m_unfl)));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic issue(logic [7:0] op);
    op_valid = 1; op_code = op;
    tick();
    op_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd12345));
    @(negedge clk);
    // R1 reset values
    check("R1 enables in reset", {29'd0, sclk_en, tclk_en, osc_en}, 32'd7);
    check("R1 mode in reset", 32'(mode), 0);
    check("R1 restart in reset", 32'(restart_req), 1);
    check("R1 flags in reset", {30'd0, flush_ready, unflushed_entry}, 0);
    rst_n = 1;
    tick();
    check("R1 restart drops", 32'(restart_req), 0);
    check("R7 vector", 32'(restart_vec), 32'h00C);

    // R8 / R2: flushed halt
    issue(8'hFF);
    check("R8 flush after NOP", 32'(flush_ready), 1);
    issue(8'h7F);
    check("R2 halt mode", 32'(mode), 1);
    check("R2 halt enables", {29'd0, sclk_en, tclk_en, osc_en}, 32'd3);
    check("R9 no unflushed", 32'(unflushed_entry), 0);

    // R4 masked irq, R5 pin and opcodes ignored in halt
    irq_req = 6'b000100; irq_en = 6'b111011; wake_pin = 1;
    op_valid = 1; op_code = 8'h6F;
    tick(4);
    check("R4 masked irq keeps halt", 32'(mode), 1);
    check("R5 pin/op ignored in halt", 32'(sclk_en), 0);
    op_valid = 0; wake_pin = 0;
    irq_en = 6'b000100;
    tick();
    check("R4 wake mode", 32'(mode), 0);
    check("R4 wake sclk", 32'(sclk_en), 1);
    check("R4 resume pulse", 32'(resume_pulse), 1);
    irq_req = 0;
    tick();
    check("R4 resume single", 32'(resume_pulse), 0);
    tick(3);
    check("R5 pin ignored in run", 32'(mode), 0);

    // R9 unflushed halt
    issue(8'h12);
    check("R8 flush cleared by other op", 32'(flush_ready), 0);
    issue(8'h7F);
    check("R9 unflushed entry still halts", 32'(mode), 1);
    check("R9 unflushed set", 32'(unflushed_entry), 1);
    irq_req = 1; irq_en = 1;
    tick();
    irq_req = 0;

    // R3 stop, R5 irq ignored, R6/R7 pin wake with settle 5
    settle_cycles = 8'd5;
    issue(8'hFF);
    issue(8'h6F);
    check("R3 stop mode", 32'(mode), 2);
    check("R3 stop enables", {29'd0, sclk_en, tclk_en, osc_en}, 0);
    irq_req = '1; irq_en = '1;
    tick(3);
    check("R5 irq ignored in stop", 32'(mode), 2);
    irq_req = 0; irq_en = 0;
    wake_pin = 1;
    tick(2);
    check("R6 stop holds during sync", 32'(mode), 2);
    tick();
    wake_pin = 0;
    check("R6 settle mode", 32'(mode), 3);
    check("R6 settle enables", {29'd0, sclk_en, tclk_en, osc_en}, 32'd1);
    tick(4);
    check("R7 still settling", 32'(mode), 3);
    tick();
    check("R7 run after settle", 32'(mode), 0);
    check("R7 enables after settle", {29'd0, sclk_en, tclk_en, osc_en}, 32'd7);
    check("R7 restart pulse", 32'(restart_req), 1);
    check("R9 sticky across stop", 32'(unflushed_entry), 1);
    check("R8 flush cleared on restart", 32'(flush_ready), 0);
    tick();
    check("R7 restart single", 32'(restart_req), 0);

    // R7 settle of zero acts as one
    settle_cycles = 0;
    issue(8'h6F);
    wake_pin = 1;
    tick(3);
    wake_pin = 0;
    check("R7 zero settle enters settle", 32'(mode), 3);
    tick();
    check("R7 zero settle one cycle", 32'(mode), 0);

    // R10 reset during halt
    issue(8'h7F);
    rst_n = 0;
    tick();
    check("R10 reset mode", 32'(mode), 0);
    check("R10 reset enables", {29'd0, sclk_en, tclk_en, osc_en}, 32'd7);
    check("R10 reset clears sticky", 32'(unflushed_entry), 0);
    check("R10 reset restart", 32'(restart_req), 1);
    rst_n = 1;
    tick();
    check_model("R1 model sync");

    // Random phase against the cycle model
    for (int i = 0; i < 20000; i++) begin
      int pick;
      pick = int'($urandom_range(0, 3));
      op_valid = ($urandom_range(0, 3) != 0);
      op_code = (pick == 0) ? 8'hFF : (pick == 1) ? 8'h7F : (pick == 2) ? 8'h6F : 8'($urandom);
      irq_req = ($urandom_range(0, 5) == 0) ? IRQ_W'($urandom) : '0;
      irq_en = IRQ_W'($urandom);
      if ($urandom_range(0, 7) == 0) wake_pin = ~wake_pin;
      if ($urandom_range(0, 15) == 0) settle_cycles = CNT_W'($urandom_range(0, 7));
      rst_n = ($urandom_range(0, 999) != 0);
      tick();
      check_model(rst_n ? "R2 R3 R4 R5 R6 R7 R8 R9 random" : "R10 random reset");
    end
    finish_run();
  end
endmodule